// File: doc/BRIEF.md
# Command Frame Relay

This block belongs to a buffered memory module that sits in a point-to-point daisy chain. Each clock cycle it can take one southbound command frame from the upstream link. It sends every frame on to the next module unchanged and one cycle later, so all modules in the chain see the same stream after a fixed per-hop delay.

The block also decodes each frame. A frame carries a module identifier, an operation code, an address field and a write payload of eight data bytes plus one ECC byte. The block acts on a frame only when the identifier equals the module's strapped ID and the operation code names a real DRAM operation. It then drives a one-cycle command strobe on its local DRAM-side port, together with the operation, the address and, for writes, the data and ECC byte. Frames for other modules, empty slots and unknown codes leave the local port idle and unchanged.

Top module: `cmd_frame_relay`

## Requirements
- R1: `fwd_valid` equals the value `in_valid` had on the previous clock edge, so the block accepts and forwards one frame in every cycle.
- R2: When `in_valid` is high, `fwd_frame` shows all 120 bits of that `in_frame` unchanged on the next cycle, whatever its module ID or operation code.
- R3: On a cycle where `in_valid` is low, `fwd_frame` keeps its previous value.
- R4: The frame layout is: module ID in [119:117] and operation code in [116:114] (0 empty slot, 1 read, 2 write, 3 activate, 4 precharge, 5 to 7 unassigned). `loc_valid` is high for exactly the one cycle after a valid frame whose ID equals `my_id` and whose code is 1 to 4.
- R5: A valid frame whose ID differs from `my_id` leaves `loc_valid` low, and `loc_op`, `loc_addr`, `loc_wdata` and `loc_ecc` unchanged.
- R6: A valid frame for this module with code 0 (empty slot) or an unassigned code 5 to 7 leaves `loc_valid` low and all local outputs unchanged.
- R7: Together with `loc_valid`, `loc_op` shows the frame's code and `loc_addr` shows frame bits [113:72]. Both hold until the next accepted local command.
- R8: `loc_wdata` (frame bits [63:0]) and `loc_ecc` (frame bits [71:64]) load only on an accepted write. They keep their values through reads, activates and precharges.
- R9: While reset is asserted, and until it has been released through the two-stage synchronizer, `fwd_valid` and `loc_valid` are low and the local fields read zero, even when valid frames arrive.
- R10: Frames on consecutive cycles are each forwarded and decoded on their own, with no gap and no merging. This includes back-to-back writes to this module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock, one frame per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id | input | 3 | Strapped module identifier |
| in_valid | input | 1 | Upstream frame present |
| in_frame | input | 120 | Upstream command frame |
| fwd_valid | output | 1 | Downstream frame present |
| fwd_frame | output | 120 | Frame relayed to the next module |
| loc_valid | output | 1 | One-cycle local command strobe |
| loc_op | output | 3 | Local operation code |
| loc_addr | output | 42 | Local address, bank and row field |
| loc_wdata | output | 64 | Local write data |
| loc_ecc | output | 8 | Local write ECC byte |

## Verification
The bench uses the default parameters: a 3-bit ID, a 42-bit address field and a 64-bit data field with an 8-bit ECC byte. With a 3-bit ID, all eight strap values and every mismatching ID can be reached. With a 3-bit code field, the three unassigned codes occur next to the four real operations. Random frames, biased towards the module's own ID, are mixed with directed cases: back-to-back writes, a read between two writes, frames sent during reset, and a change of strap between phases.

// File: rtl/frame_relay_pkg.sv
`timescale 1ns/1ps
package frame_relay_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_ACT   = 3'd3,
    OP_PRE   = 3'd4
  } op_e;
endpackage

// File: rtl/relay_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module relay_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/frame_fwd_stage.sv
`timescale 1ns/1ps
// One registered hop toward the next module.
module frame_fwd_stage #(
  parameter int FRAME_W = 120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_frame,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_frame
);
  logic               valid_q, valid_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               frame_en;

  always_comb begin
    frame_en = in_valid;
    valid_d  = in_valid;
    frame_d  = frame_en ? in_frame : frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      frame_q <= '0;
    end else begin
      valid_q <= valid_d;
      frame_q <= frame_d;
    end
  end

  assign out_valid = valid_q;
  assign out_frame = frame_q;
endmodule

// File: rtl/frame_decode.sv
`timescale 1ns/1ps
// Splits a frame into fields and decides whether this module acts on it.
module frame_decode
  import frame_relay_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 42,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  localparam int FRAME_W  = ID_W + OP_W + ADDR_W + ECC_W + DATA_W,
  localparam int ECC_LSB  = DATA_W,
  localparam int ADDR_LSB = DATA_W + ECC_W,
  localparam int OP_LSB   = ADDR_LSB + ADDR_W,
  localparam int ID_LSB   = OP_LSB + OP_W
) (
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic [ID_W-1:0]    my_id,
  output logic               hit,
  output logic               hit_write,
  output logic [OP_W-1:0]    f_op,
  output logic [ADDR_W-1:0]  f_addr,
  output logic [DATA_W-1:0]  f_data,
  output logic [ECC_W-1:0]   f_ecc
);
  logic [ID_W-1:0] f_id;
  logic            id_match;
  logic            op_known;

  always_comb begin
    f_id     = in_frame[ID_LSB   +: ID_W];
    f_op     = in_frame[OP_LSB   +: OP_W];
    f_addr   = in_frame[ADDR_LSB +: ADDR_W];
    f_ecc    = in_frame[ECC_LSB  +: ECC_W];
    f_data   = in_frame[0        +: DATA_W];
    id_match = (f_id == my_id);
    op_known = (f_op == OP_READ) || (f_op == OP_WRITE) ||
               (f_op == OP_ACT)  || (f_op == OP_PRE);
    hit       = in_valid && id_match && op_known;
    hit_write = hit && (f_op == OP_WRITE);
  end
endmodule

// File: rtl/local_cmd_port.sv
`timescale 1ns/1ps
// Registers for the DRAM-side command port. Command and address load on
// any accepted command, the write payload only on accepted writes.
module local_cmd_port
  import frame_relay_pkg::*;
#(
  parameter int ADDR_W = 42,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              hit_write,
  input  logic [OP_W-1:0]   f_op,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] f_data,
  input  logic [ECC_W-1:0]  f_ecc,
  output logic              loc_valid,
  output logic [OP_W-1:0]   loc_op,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [DATA_W-1:0] loc_wdata,
  output logic [ECC_W-1:0]  loc_ecc
);
  logic              valid_q, valid_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [ECC_W-1:0]  ecc_q, ecc_d;
  logic              cmd_en, wr_en;

  always_comb begin
    cmd_en  = hit;
    wr_en   = hit_write;
    valid_d = cmd_en;
    op_d    = cmd_en ? f_op   : op_q;
    addr_d  = cmd_en ? f_addr : addr_q;
    wdata_d = wr_en  ? f_data : wdata_q;
    ecc_d   = wr_en  ? f_ecc  : ecc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      ecc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      ecc_q   <= ecc_d;
    end
  end

  assign loc_valid = valid_q;
  assign loc_op    = op_q;
  assign loc_addr  = addr_q;
  assign loc_wdata = wdata_q;
  assign loc_ecc   = ecc_q;
endmodule

// File: rtl/cmd_frame_relay.sv
`timescale 1ns/1ps
module cmd_frame_relay
  import frame_relay_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 42,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  localparam int FRAME_W = ID_W + OP_W + ADDR_W + ECC_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    my_id,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_frame,
  output logic               fwd_valid,
  output logic [FRAME_W-1:0] fwd_frame,
  output logic               loc_valid,
  output logic [OP_W-1:0]    loc_op,
  output logic [ADDR_W-1:0]  loc_addr,
  output logic [DATA_W-1:0]  loc_wdata,
  output logic [ECC_W-1:0]   loc_ecc
);
  logic              rst_n_sync;
  logic              dec_hit, dec_hit_write;
  logic [OP_W-1:0]   dec_op;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;
  logic [ECC_W-1:0]  dec_ecc;

  relay_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  frame_fwd_stage #(.FRAME_W(FRAME_W)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (in_valid),
    .in_frame  (in_frame),
    .out_valid (fwd_valid),
    .out_frame (fwd_frame)
  );

  frame_decode #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W)
  ) u_dec (
    .in_valid  (in_valid),
    .in_frame  (in_frame),
    .my_id     (my_id),
    .hit       (dec_hit),
    .hit_write (dec_hit_write),
    .f_op      (dec_op),
    .f_addr    (dec_addr),
    .f_data    (dec_data),
    .f_ecc     (dec_ecc)
  );

  local_cmd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W)
  ) u_loc (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .hit       (dec_hit),
    .hit_write (dec_hit_write),
    .f_op      (dec_op),
    .f_addr    (dec_addr),
    .f_data    (dec_data),
    .f_ecc     (dec_ecc),
    .loc_valid (loc_valid),
    .loc_op    (loc_op),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_ecc   (loc_ecc)
  );
endmodule

// File: rtl/cmd_frame_relay_checker.sv
`timescale 1ns/1ps
module cmd_frame_relay_checker
  import frame_relay_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 42,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  localparam int FRAME_W = ID_W + OP_W + ADDR_W + ECC_W + DATA_W,
  localparam int OP_LSB  = DATA_W + ECC_W + ADDR_W,
  localparam int ID_LSB  = OP_LSB + OP_W
) (
  input logic               clk,
  input logic               rst_ok,
  input logic [ID_W-1:0]    my_id,
  input logic               in_valid,
  input logic [FRAME_W-1:0] in_frame,
  input logic               fwd_valid,
  input logic [FRAME_W-1:0] fwd_frame,
  input logic               loc_valid,
  input logic [OP_W-1:0]    loc_op,
  input logic [ADDR_W-1:0]  loc_addr,
  input logic [DATA_W-1:0]  loc_wdata,
  input logic [ECC_W-1:0]   loc_ecc
);
  logic [ID_W-1:0] c_id;
  logic [OP_W-1:0] c_op;
  logic            c_real_op;

  always_comb begin
    c_id      = in_frame[ID_LSB +: ID_W];
    c_op      = in_frame[OP_LSB +: OP_W];
    c_real_op = (c_op >= 3'd1) && (c_op <= 3'd4);
  end

  p_fwd_valid_set_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> fwd_valid);
  p_fwd_valid_clr_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !fwd_valid);
  p_fwd_frame_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> (fwd_frame == $past(in_frame)));
  p_fwd_hold_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(fwd_frame));
  p_loc_hit_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (c_id == my_id) && c_real_op) |=> loc_valid);
  p_loc_other_id_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (c_id != my_id)) |=> (!loc_valid && $stable(loc_addr)));
  p_loc_no_op_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !c_real_op) |=> (!loc_valid && $stable(loc_op)));
  p_loc_idle_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !loc_valid);
  p_loc_op_legal_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    loc_valid |-> ((loc_op >= 3'd1) && (loc_op <= 3'd4)));
  p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !(loc_valid && (loc_op == OP_WRITE)) |-> ($stable(loc_wdata) && $stable(loc_ecc)));
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_ok |-> (!fwd_valid && !loc_valid));
endmodule

bind cmd_frame_relay cmd_frame_relay_checker #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W)
) u_checker (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .my_id     (my_id),
  .in_valid  (in_valid),
  .in_frame  (in_frame),
  .fwd_valid (fwd_valid),
  .fwd_frame (fwd_frame),
  .loc_valid (loc_valid),
  .loc_op    (loc_op),
  .loc_addr  (loc_addr),
  .loc_wdata (loc_wdata),
  .loc_ecc   (loc_ecc)
);

// File: tb/test_cmd_frame_relay.sv
`timescale 1ns/1ps
module test_cmd_frame_relay;
  localparam int FW = 120;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [2:0]     my_id;
  logic           in_valid;
  logic [FW-1:0]  in_frame;
  logic           fwd_valid;
  logic [FW-1:0]  fwd_frame;
  logic           loc_valid;
  logic [2:0]     loc_op;
  logic [41:0]    loc_addr;
  logic [63:0]    loc_wdata;
  logic [7:0]     loc_ecc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected state
  logic          e_fv;
  logic [FW-1:0] e_ff;
  logic          e_lv;
  logic [2:0]    e_op;
  logic [41:0]   e_addr;
  logic [63:0]   e_wd;
  logic [7:0]    e_ecc;

  always #10 clk = ~clk;  // 50 MHz

  cmd_frame_relay i_cmd_frame_relay (
    .clk(clk), .rst_n(rst_n), .my_id(my_id),
    .in_valid(in_valid), .in_frame(in_frame),
    .fwd_valid(fwd_valid), .fwd_frame(fwd_frame),
    .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_ecc(loc_ecc)
  );

  function automatic logic [FW-1:0] mk(input logic [2:0] id, input logic [2:0] op,
                                       input logic [41:0] addr, input logic [7:0] ecc,
                                       input logic [63:0] data);
    return {id, op, addr, ecc, data};
  endfunction

  // R4 acceptance rule: matching ID and code 1..4
  function automatic bit accepts(input logic v, input logic [FW-1:0] f, input logic [2:0] id);
    return v && (f[119:117] == id) && (f[116:114] >= 3'd1) && (f[116:114] <= 3'd4);
  endfunction

  task automatic chk(input string req, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  task automatic model_reset();
    e_fv = 1'b0; e_ff = '0; e_lv = 1'b0;
    e_op = '0; e_addr = '0; e_wd = '0; e_ecc = '0;
  endtask

  // Drive at negedge, capture at posedge, compare at the following negedge.
  task automatic send(input logic v, input logic [FW-1:0] f, input string tag);
    string lv_req;
    bit    hit;
    in_valid = v;
    in_frame = f;
    @(posedge clk);
    hit  = accepts(v, f, my_id);
    e_fv = v;
    if (v) e_ff = f;
    e_lv = hit;
    if (hit) begin
      e_op   = f[116:114];
      e_addr = f[113:72];
      if (f[116:114] == 3'd2) begin
        e_wd  = f[63:0];
        e_ecc = f[71:64];
      end
    end
    @(negedge clk);
    if (hit)                        lv_req = "R4";
    else if (!v)                    lv_req = "R1";
    else if (f[119:117] != my_id)   lv_req = "R5";
    else                            lv_req = "R6";
    chk("R1", tag, 128'(fwd_valid), 128'(e_fv));
    chk(v ? "R2" : "R3", tag, 128'(fwd_frame), 128'(e_ff));
    chk(lv_req, tag, 128'(loc_valid), 128'(e_lv));
    chk("R7", tag, {83'd0, loc_op, loc_addr}, {83'd0, e_op, e_addr});
    chk("R8", tag, {56'd0, loc_ecc, loc_wdata}, {56'd0, e_ecc, e_wd});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    my_id = 3'd5;
    in_valid = 1'b0;
    in_frame = '0;
    model_reset();
    repeat (3) @(negedge clk);

    // R9: frames during reset are not acted on
    in_valid = 1'b1;
    in_frame = mk(3'd5, 3'd2, 42'h1234, 8'hAA, 64'hDEAD);
    repeat (2) @(negedge clk);
    chk("R9", "reset fwd", 128'(fwd_valid), 128'd0);
    chk("R9", "reset loc", 128'(loc_valid), 128'd0);
    chk("R9", "reset fields", {loc_op, loc_addr, loc_ecc, loc_wdata}, 128'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "sync window", 128'({fwd_valid, loc_valid}), 128'd0);
    repeat (2) @(negedge clk);

    // directed cases
    send(1'b1, mk(3'd5, 3'd2, 42'h2_0000_0001, 8'h3C, 64'h0123_4567_89AB_CDEF), "R4 write");
    send(1'b1, mk(3'd5, 3'd1, 42'h0_0000_0F00, 8'hFF, 64'hFFFF_0000_FFFF_0000), "R8 read keeps data");
    send(1'b1, mk(3'd2, 3'd2, 42'h3FF_FFFF_FFFF, 8'h11, 64'h1111), "R5 other id");
    send(1'b1, mk(3'd5, 3'd0, 42'h55, 8'h22, 64'h2222), "R6 empty slot");
    send(1'b1, mk(3'd5, 3'd7, 42'h66, 8'h33, 64'h3333), "R6 code 7");
    send(1'b1, mk(3'd5, 3'd5, 42'h77, 8'h44, 64'h4444), "R6 code 5");
    send(1'b0, mk(3'd5, 3'd2, 42'h88, 8'h55, 64'h5555), "R3 idle");
    // R10: back-to-back writes to this module
    send(1'b1, mk(3'd5, 3'd2, 42'h101, 8'hA1, 64'hA1A1), "R10 first");
    send(1'b1, mk(3'd5, 3'd2, 42'h202, 8'hB2, 64'hB2B2), "R10 second");
    send(1'b1, mk(3'd5, 3'd3, 42'h303, 8'hC3, 64'hC3C3), "R10 activate");
    send(1'b1, mk(3'd5, 3'd4, 42'h404, 8'hD4, 64'hD4D4), "R10 precharge");
    send(1'b0, '0, "R1 gap");

    // strap changed while idle
    my_id = 3'd2;
    @(negedge clk);
    send(1'b1, mk(3'd2, 3'd2, 42'h2A, 8'h5A, 64'h5A5A_5A5A), "R4 new strap");
    send(1'b1, mk(3'd5, 3'd2, 42'h2B, 8'h6B, 64'h6B6B), "R5 old strap");

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [2:0] id;
      id = ($urandom % 2 == 0) ? my_id : 3'($urandom);
      f = mk(id, 3'($urandom), 42'({$urandom, $urandom}), 8'($urandom),
             {$urandom, $urandom});
      send(($urandom % 5) != 0, f, "random");
      if (i == 300) begin
        in_valid = 1'b0;
        my_id = 3'($urandom);
        @(negedge clk);
        e_fv = 1'b0; e_lv = 1'b0;
      end
    end
    send(1'b0, '0, "R1 tail");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule